// File: doc/BRIEF.md
# Bit-Gathering Xorshift Word Generator

This block produces a repeatable stream of pseudo-random 32-bit words, meant for filling a placeholder memory image with deterministic content. A 32-bit xorshift state advances once per clock. Each output word is assembled from the lowest state bit seen after each of 32 consecutive updates. The finished word, not the internal state, then seeds the next word, so the stream depends only on the fixed start value of 1.

A sequence begins with a one-cycle start strobe, which also samples the word-count limit. Each finished word is shown with a one-cycle valid pulse and its index. The done flag rises with the last word and holds until the next start. A typical limit is 2048 words, which fills 8 KiB.

Top module: `xorshift_word_gen`

## Requirements
- R1: One state update applies three xor-with-shift steps in this order: state ^= state << 13, then state ^= state >> 17, then state ^= state << 5, all in 32 bits.
- R2: A word takes exactly 32 updates. The state's bit 0 after update i (counted from 0) becomes bit i of the word, so the first update supplies the least significant bit.
- R3: Every sequence, including the first after reset, starts from state value 1.
- R4: Each word after the first starts from the completed previous output word as its state.
- R5: The block performs one update per clock. `wordValid` is high for exactly one cycle per word. The first word's pulse is visible 32 clock edges after the edge that samples `startIn`, and later pulses follow every 32 cycles.
- R6: `wordIdx` equals 0 for the first word of a sequence and increases by one for each later word.
- R7: `seqDone` rises in the same cycle as the valid pulse of word number limit-1. After that no further valid pulse appears until the next accepted start.
- R8: `startIn` has no effect while a sequence is running. The words, their timing and the limit in use all continue unchanged.
- R9: A start after `seqDone` clears `seqDone` and restarts from state 1 with index 0. It samples a fresh limit.
- R10: A start with a limit of 0 sets `seqDone` on the next cycle and produces no words.
- R11: After reset, `wordValid` and `seqDone` are 0 and `wordIdx` and `wordOut` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| startIn | input | 1 | Start strobe; sampled only when idle |
| wordLimit | input | IDX_W | Number of words to produce, sampled at start |
| wordOut | output | WORD_W | Last completed word |
| wordValid | output | 1 | One-cycle pulse when `wordOut` is new |
| wordIdx | output | IDX_W | Index of the word on `wordOut` |
| seqDone | output | 1 | High once the limit has been reached |

## Verification
Every word is compared against a bench model of the update and the bit gathering. A design that shifted in the wrong order, took the wrong bit, or reused the internal state as the next seed would diverge from the model at the first or second word. The bench also checks the exact cycle of every valid pulse and of the done edge across whole sequences. This catches off-by-one step counts and a done flag that rises one word early or late. It then pulses start in the middle of a run with a different limit, restarts after done to confirm the stream repeats from seed 1, and uses a zero limit to confirm that done appears at once with no words.

// File: rtl/xsw_pkg.sv
package xsw_pkg;
  // Strobes passed from the sequencing control to the datapath
  typedef struct packed {
    logic loadSeed;  // restart from the fixed seed
    logic step;      // apply one state update and gather one bit
    logic finish;    // this step completes a word
  } xswStrobes_t;
endpackage

// File: rtl/xsw_datapath.sv
module xsw_datapath
  import xsw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int SHIFT_A = 13,
  parameter int SHIFT_B = 17,
  parameter int SHIFT_C = 5,
  parameter logic [WORD_W-1:0] SEED = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  xswStrobes_t       strobes,
  output logic [WORD_W-1:0] wordOut
);
  logic [WORD_W-1:0] stateReg;
  logic [WORD_W-1:0] gatherReg;
  logic [WORD_W-1:0] stateNext;
  logic [WORD_W-1:0] wordNext;

  function automatic logic [WORD_W-1:0] xsUpdate(input logic [WORD_W-1:0] s);
    logic [WORD_W-1:0] t;
    t = s ^ (s << SHIFT_A);
    t = t ^ (t >> SHIFT_B);
    t = t ^ (t << SHIFT_C);
    return t;
  endfunction

  always_comb begin
    stateNext = xsUpdate(stateReg);
    // New bit enters at the top; after WORD_W shifts the first bit sits at bit 0
    wordNext  = {stateNext[0], gatherReg[WORD_W-1:1]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stateReg  <= SEED;
      gatherReg <= '0;
      wordOut   <= '0;
    end else if (strobes.loadSeed) begin
      stateReg  <= SEED;
      gatherReg <= '0;
    end else if (strobes.step) begin
      gatherReg <= wordNext;
      if (strobes.finish) begin
        wordOut  <= wordNext;
        stateReg <= wordNext;  // finished word seeds the next one
      end else begin
        stateReg <= stateNext;
      end
    end
  end

  assert_seed_load_R3: assert property (@(posedge clk) disable iff (rst)
    strobes.loadSeed |=> stateReg == SEED);
  assert_word_chain_R4: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && strobes.finish) |=> stateReg == wordOut);
  assert_step_order_R1: assert property (@(posedge clk) disable iff (rst)
    (strobes.step && !strobes.finish && !strobes.loadSeed) |=>
      stateReg == xsUpdate($past(stateReg)));
endmodule

// File: rtl/xsw_control.sv
module xsw_control
  import xsw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             startIn,
  input  logic [IDX_W-1:0] wordLimit,
  output xswStrobes_t      strobes,
  output logic             wordValid,
  output logic [IDX_W-1:0] wordIdx,
  output logic             seqDone
);
  localparam int CNT_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WORD_W - 1);

  logic             running;
  logic [CNT_W-1:0] stepCnt;
  logic [IDX_W-1:0] wordCnt;
  logic [IDX_W-1:0] wordCntNext;
  logic [IDX_W-1:0] limitReg;
  logic             accept;

  always_comb begin
    accept           = startIn && !running;
    wordCntNext      = wordCnt + 1'b1;
    strobes.loadSeed = accept;
    strobes.step     = running;
    strobes.finish   = running && (stepCnt == LAST_STEP);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      running   <= 1'b0;
      stepCnt   <= '0;
      wordCnt   <= '0;
      limitReg  <= '0;
      wordValid <= 1'b0;
      wordIdx   <= '0;
      seqDone   <= 1'b0;
    end else begin
      wordValid <= 1'b0;
      if (accept) begin
        limitReg <= wordLimit;
        stepCnt  <= '0;
        wordCnt  <= '0;
        wordIdx  <= '0;
        if (wordLimit == '0) begin
          seqDone <= 1'b1;
          running <= 1'b0;
        end else begin
          seqDone <= 1'b0;
          running <= 1'b1;
        end
      end else if (running) begin
        stepCnt <= stepCnt + 1'b1;
        if (stepCnt == LAST_STEP) begin
          wordValid <= 1'b1;
          wordIdx   <= wordCnt;
          wordCnt   <= wordCntNext;
          if (wordCntNext == limitReg) begin
            running <= 1'b0;
            seqDone <= 1'b1;
          end
        end
      end
    end
  end

  assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (rst)
    wordValid |=> !wordValid);
  assert_quiet_after_done_R7: assert property (@(posedge clk) disable iff (rst)
    (seqDone && !startIn) |=> !wordValid && seqDone);
  assert_idx_in_range_R6: assert property (@(posedge clk) disable iff (rst)
    wordValid |-> wordIdx < limitReg);
  assert_start_ignored_R8: assert property (@(posedge clk) disable iff (rst)
    (running && startIn) |=> $stable(limitReg));
  assert_zero_limit_R10: assert property (@(posedge clk) disable iff (rst)
    (accept && wordLimit == '0) |=> seqDone && !running);
endmodule

// File: rtl/xorshift_word_gen.sv
module xorshift_word_gen
  import xsw_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int IDX_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              startIn,
  input  logic [IDX_W-1:0]  wordLimit,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid,
  output logic [IDX_W-1:0]  wordIdx,
  output logic              seqDone
);
  xswStrobes_t strobes;

  xsw_control #(.WORD_W(WORD_W), .IDX_W(IDX_W)) control_i (
    .clk(clk), .rst(rst), .startIn(startIn), .wordLimit(wordLimit),
    .strobes(strobes), .wordValid(wordValid), .wordIdx(wordIdx),
    .seqDone(seqDone)
  );

  xsw_datapath #(.WORD_W(WORD_W)) datapath_i (
    .clk(clk), .rst(rst), .strobes(strobes), .wordOut(wordOut)
  );
endmodule

// File: tb/xorshift_word_gen_tb.sv
`timescale 1ns/1ps
module xorshift_word_gen_tb_top;
  localparam int IDX_W = 16;
  logic clk = 1'b0;
  logic rst;
  logic startIn;
  logic [IDX_W-1:0] wordLimit;
  logic [31:0] wordOut;
  logic wordValid;
  logic [IDX_W-1:0] wordIdx;
  logic seqDone;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  xorshift_word_gen #(.WORD_W(32), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .startIn(startIn), .wordLimit(wordLimit),
    .wordOut(wordOut), .wordValid(wordValid), .wordIdx(wordIdx),
    .seqDone(seqDone)
  );

  function automatic logic [31:0] modelStep(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    y = y ^ (y << 5);
    return y;
  endfunction

  function automatic logic [31:0] modelWord(input logic [31:0] seed);
    logic [31:0] s = seed;
    logic [31:0] w = '0;
    for (int i = 0; i < 32; i++) begin
      s = modelStep(s);
      w[i] = s[0];
    end
    return w;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input int lim);
    @(negedge clk);
    startIn = 1'b1;
    wordLimit = IDX_W'(lim);
    @(posedge clk);
    @(negedge clk);
    startIn = 1'b0;
  endtask

  // Runs one sequence; optionally pulses start mid-run with another limit (R8)
  task automatic runSeq(input int lim, input bit injectStart);
    logic [31:0] seed = 32'd1;
    logic [31:0] expW;
    int k = 0;
    pulseStart(lim);
    check(seqDone == (lim == 0), "R9", "done after start", seqDone, (lim == 0));
    for (int n = 1; n <= 32 * lim + 40; n++) begin
      bit expV;
      if (injectStart && n == 50) begin
        startIn = 1'b1;
        wordLimit = IDX_W'(1);
      end
      if (injectStart && n == 51) startIn = 1'b0;
      @(negedge clk);
      expV = (n % 32 == 0) && (n / 32 <= lim);
      check(wordValid == expV, "R5", $sformatf("valid at cycle %0d", n), wordValid, expV);
      check(seqDone == (n >= 32 * lim), "R7", $sformatf("done at cycle %0d", n),
            seqDone, (n >= 32 * lim));
      if (wordValid && expV) begin
        expW = modelWord(seed);
        check(wordOut == expW, "R2 R4", $sformatf("word %0d", k), wordOut, expW);
        check(wordIdx == IDX_W'(k), "R6", "word index", wordIdx, k);
        seed = expW;
        k++;
      end
    end
    check(k == lim, "R7", "word count", k, lim);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    rst = 1'b1;
    startIn = 1'b0;
    wordLimit = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R11: reset state
    check(wordValid == 1'b0, "R11", "valid in reset", wordValid, 0);
    check(seqDone == 1'b0, "R11", "done in reset", seqDone, 0);
    check(wordIdx == '0, "R11", "index in reset", wordIdx, 0);
    check(wordOut == '0, "R11", "word in reset", wordOut, 0);
    rst = 1'b0;
    // R1: model sanity on a hand-computed step from state 1
    check(modelStep(32'd1) == 32'h0004_2021, "R1", "model step", modelStep(32'd1), 32'h42021);
    // R3 R1 R2 R4 R5 R6 R7: first sequence
    runSeq(5, 1'b0);
    // R9: restart after done repeats the stream from seed 1
    runSeq(3, 1'b0);
    // R8: mid-run start with a different limit is ignored
    runSeq(6, 1'b1);
    // R10: zero limit
    runSeq(0, 1'b0);
    // Longer run
    runSeq(20, 1'b0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule